// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This unit gathers the interrupt events produced by a multi-channel DMA engine and turns them into a single interrupt request for the processor. Every channel reports two completion events: half of its buffer moved, and all of its buffer moved. Two further events are shared by all channels: a list-handling channel reaching the end of a linked list, and a bus abort seen by any channel.

Each event sets a sticky flag in a status register. A mask register decides which flags may raise the interrupt. The completion flags have one enable per channel. The end-of-list flag and the abort flag have one global enable each. The processor reaches the unit through a simple word-addressed register port. It can read the status, clear flags by writing ones, read and write the mask, and write a write-only trigger register. Writing the trigger sets the end-of-list flag, so the channel that walks a list can signal that the list has ended.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the status register, the mask register and `irq` are all zero.
- R2: A high `evt_half[c]` in a cycle sets status bit c. A high `evt_full[c]` sets status bit NUM_CH+c, which is bits 15:8 for the default of 8 channels. A set bit stays set until it is cleared.
- R3: A high `evt_eol` sets status bit 30. A high `evt_abort` sets status bit 31.
- R4: A write to word address 2 (the trigger register) sets status bit 30, whatever the write data. A read of address 2 returns zero.
- R5: A write to word address 0 (status) clears every status bit written as 1 and leaves the bits written as 0 unchanged.
- R6: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R7: The mask at word address 1 reads back what was written, but only in its live bits: bits 2*NUM_CH-1:0, bit 30 and bit 31. All other bits of the mask and of the status read as zero.
- R8: `irq` is the OR of (status AND mask) registered once, so it changes one clock after the status or the mask changes.
- R9: Mask bits c and NUM_CH+c gate only the half and full flags of channel c. Mask bit 30 alone gates the end-of-list flag, and mask bit 31 alone gates the abort flag.
- R10: Reads of word addresses other than 0, 1 and 2 return zero, and writes to them change neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_half | input | NUM_CH | Per-channel half-buffer done pulses |
| evt_full | input | NUM_CH | Per-channel full-buffer done pulses |
| evt_eol | input | 1 | Shared end-of-list event |
| evt_abort | input | 1 | Shared bus-abort event |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from `reg_addr`) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives a clear and a new event at the same bit in the same cycle. A design that lets the clear win would drop that event. It writes the trigger register with all-zero data: a design that decodes the data instead of the access would never set bit 30. It loads the mask with all ones and reads it back, which catches storage left live in bits that should be dead. It sets the abort flag while only the end-of-list enable is on, and the end-of-list flag while only a channel enable is on, so that a design which cross-wires the global enables raises a spurious `irq`. It samples `irq` both before and after the register stage, which catches a missing or a doubled pipeline stage.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

   localparam int unsigned DATA_W  = 32;
   localparam int unsigned EOL_BIT = 30;
   localparam int unsigned ABT_BIT = 31;

   localparam int unsigned ADDR_STAT = 0;
   localparam int unsigned ADDR_MASK = 1;
   localparam int unsigned ADDR_SOFT = 2;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_MASK,
      SEL_SOFT
   } reg_sel_e;

   function automatic logic [DATA_W-1:0] live_bits(input int unsigned n_ch);
      logic [DATA_W-1:0] v;
      v = '0;
      for (int unsigned i = 0; i < 2 * n_ch; i++) v[i] = 1'b1;
      v[EOL_BIT] = 1'b1;
      v[ABT_BIT] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
   import dma_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output reg_sel_e          sel,
   output logic              stat_wr,
   output logic              mask_wr,
   output logic              soft_wr
);

   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(ADDR_STAT))      sel = SEL_STAT;
      else if (addr == ADDR_W'(ADDR_MASK)) sel = SEL_MASK;
      else if (addr == ADDR_W'(ADDR_SOFT)) sel = SEL_SOFT;
   end

   assign stat_wr = wr && (sel == SEL_STAT);
   assign mask_wr = wr && (sel == SEL_MASK);
   assign soft_wr = wr && (sel == SEL_SOFT);

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_half,
   input  logic [NUM_CH-1:0] evt_full,
   input  logic              evt_eol,
   input  logic              evt_abort,
   input  logic              soft_set,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] clr_data,
   output logic [DATA_W-1:0] status
);

   localparam int unsigned FULL_LSB = NUM_CH;
   localparam logic [DATA_W-1:0] LIVE = live_bits(NUM_CH);

   logic [DATA_W-1:0] set_vec;

   always_comb begin
      set_vec = '0;
      set_vec[NUM_CH-1:0]               = evt_half;
      set_vec[FULL_LSB +: NUM_CH]       = evt_full;
      set_vec[EOL_BIT]                  = evt_eol | soft_set;
      set_vec[ABT_BIT]                  = evt_abort;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (LIVE[b]) begin : g_live
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                     flag_q <= 1'b0;
            else if (set_vec[b])            flag_q <= 1'b1;
            else if (clr_en && clr_data[b]) flag_q <= 1'b0;
         end
         assign status[b] = flag_q;

         assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[b] |=> status[b]);
         assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (status[b] && !(clr_en && clr_data[b])) |=> status[b]);
         assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_data[b] && !set_vec[b]) |=> !status[b]);
      end else begin : g_dead
         assign status[b] = 1'b0;
      end
   end

endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] mask
);

   localparam logic [DATA_W-1:0] LIVE = live_bits(NUM_CH);

   logic [DATA_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     mask_q <= '0;
      else if (wr_en) mask_q <= wr_data & LIVE;
   end

   assign mask = mask_q;

   assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mask));
   assert_mask_dead_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask & ~LIVE) == '0);

endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine
   import dma_irq_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] status,
   input  logic [DATA_W-1:0] mask,
   output logic              irq
);

   logic pend;
   assign pend = |(status & mask);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq = irq_q;

      assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
         pend |=> irq);
      assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !pend |=> !irq);
   end else begin : g_comb
      assign irq = pend;
   end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
   import dma_irq_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned ADDR_W  = 4,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_half,
   input  logic [NUM_CH-1:0] evt_full,
   input  logic              evt_eol,
   input  logic              evt_abort,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq
);

   if (NUM_CH < 1 || 2 * NUM_CH > EOL_BIT) begin : g_bad_ch
      $error("dma_irq_ctrl: NUM_CH must be 1..15");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("dma_irq_ctrl: ADDR_W must be at least 2");
   end

   reg_sel_e          sel;
   logic              stat_wr, mask_wr, soft_wr;
   logic [DATA_W-1:0] status, mask;

   dma_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr    (reg_addr),
      .wr      (reg_wr),
      .sel     (sel),
      .stat_wr (stat_wr),
      .mask_wr (mask_wr),
      .soft_wr (soft_wr)
   );

   dma_irq_status #(.NUM_CH(NUM_CH)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_half  (evt_half),
      .evt_full  (evt_full),
      .evt_eol   (evt_eol),
      .evt_abort (evt_abort),
      .soft_set  (soft_wr),
      .clr_en    (stat_wr),
      .clr_data  (reg_wdata),
      .status    (status)
   );

   dma_irq_mask #(.NUM_CH(NUM_CH)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mask_wr),
      .wr_data (reg_wdata),
      .mask    (mask)
   );

   dma_irq_combine #(.REG_OUT(REG_OUT)) u_combine (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status),
      .mask   (mask),
      .irq    (irq)
   );

   always_comb begin
      unique case (sel)
         SEL_STAT: reg_rdata = status;
         SEL_MASK: reg_rdata = mask;
         default:  reg_rdata = '0;
      endcase
   end

   assert_soft_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      soft_wr |=> status[EOL_BIT]);
   assert_abort_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_abort |=> status[ABT_BIT]);
   assert_rd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE || sel == SEL_SOFT) |-> (reg_rdata == '0));

endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;

   localparam int NCH = 8;
   localparam int AW  = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] evt_half = '0;
   logic [NCH-1:0] evt_full = '0;
   logic           evt_eol = 1'b0;
   logic           evt_abort = 1'b0;
   logic [AW-1:0]  reg_addr = '0;
   logic           reg_wr = 1'b0;
   logic [31:0]    reg_wdata = '0;
   logic [31:0]    reg_rdata;
   logic           irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dma_irq_ctrl #(.NUM_CH(NCH), .ADDR_W(AW)) u_dma_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_half(evt_half), .evt_full(evt_full),
      .evt_eol(evt_eol), .evt_abort(evt_abort), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [NCH-1:0] h, input logic [NCH-1:0] f,
                        input logic e, input logic ab);
      @(negedge clk);
      evt_half = h; evt_full = f; evt_eol = e; evt_abort = ab;
      @(negedge clk);
      evt_half = '0; evt_full = '0; evt_eol = 1'b0; evt_abort = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(0, v); check("R1 status", v, 32'h0);
      rd(1, v); check("R1 mask", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_mask_live;
      logic [31:0] v;
      wr(1, 32'hFFFF_FFFF);
      rd(1, v); check("R7 mask live bits", v, 32'hC000_FFFF);
      wr(1, 32'h0);
   endtask

   task automatic t_events;
      logic [31:0] v;
      pulse(8'h05, 8'h80, 1'b0, 1'b0);
      rd(0, v); check("R2 half/full set", v, 32'h0000_8005);
      @(negedge clk);
      rd(0, v); check("R2 sticky", v, 32'h0000_8005);
      wr(0, 32'h0000_0001);
      rd(0, v); check("R5 w1c", v, 32'h0000_8004);
      wr(0, 32'h0);
      rd(0, v); check("R5 zero write keeps", v, 32'h0000_8004);
      pulse('0, '0, 1'b1, 1'b0);
      rd(0, v); check("R3 eol", v, 32'h4000_8004);
      pulse('0, '0, 1'b0, 1'b1);
      rd(0, v); check("R3 abort", v, 32'hC000_8004);
      wr(0, 32'hFFFF_FFFF);
      rd(0, v); check("R5 clear all", v, 32'h0);
   endtask

   task automatic t_soft;
      logic [31:0] v;
      wr(2, 32'h0);
      rd(0, v); check("R4 soft sets bit30", v, 32'h4000_0000);
      rd(2, v); check("R4 soft reads zero", v, 32'h0);
      wr(0, 32'h4000_0000);
   endtask

   task automatic t_collide;
      logic [31:0] v;
      @(negedge clk);
      evt_half = 8'h02; reg_addr = 0; reg_wdata = 32'h0000_0002; reg_wr = 1'b1;
      @(negedge clk);
      evt_half = '0; reg_wr = 1'b0; reg_wdata = '0;
      rd(0, v); check("R6 event beats clear", v, 32'h0000_0002);
      wr(0, 32'h0000_0002);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      pulse('0, 8'h01, 1'b1, 1'b0);
      @(negedge clk);
      check("R8 masked off no irq", {31'b0, irq}, 32'h0);
      wr(1, 32'h4000_0000);
      check("R8 irq not yet", {31'b0, irq}, 32'h0);
      @(negedge clk);
      check("R8 irq one cycle later", {31'b0, irq}, 32'h1);
      wr(0, 32'h4000_0000);
      @(negedge clk);
      check("R8 irq drops after clear", {31'b0, irq}, 32'h0);
      pulse('0, '0, 1'b0, 1'b1);
      @(negedge clk);
      check("R9 abort not under eol enable", {31'b0, irq}, 32'h0);
      wr(1, 32'h0000_0100);
      @(negedge clk);
      check("R9 full ch0 enable", {31'b0, irq}, 32'h1);
      wr(0, 32'h0000_0100);
      pulse('0, '0, 1'b1, 1'b0);
      wr(1, 32'h0000_0008);
      @(negedge clk);
      check("R9 eol not under channel enable", {31'b0, irq}, 32'h0);
      wr(1, 32'h8000_0000);
      @(negedge clk);
      check("R9 abort enable", {31'b0, irq}, 32'h1);
      wr(0, 32'hFFFF_FFFF);
      wr(1, 32'h0);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr(1, 32'h0000_0003);
      pulse(8'h01, '0, 1'b0, 1'b0);
      wr(5, 32'hFFFF_FFFF);
      rd(0, v); check("R10 status untouched", v, 32'h0000_0001);
      rd(1, v); check("R10 mask untouched", v, 32'h0000_0003);
      rd(5, v); check("R10 unmapped reads zero", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask_live();
      t_events();
      t_soft();
      t_collide();
      t_irq();
      t_unmapped();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule